// File: doc/BRIEF.md
# Instruction Fetch Stage with Program Halfword Read Port

This block is the front half of a two-stage pipeline. It keeps a 23-bit program counter and reads one 24-bit instruction per cycle from a synchronous program store. While the downstream stage executes one instruction, the next one is already being fetched. The fetched instruction leaves on a valid/ready stream together with the address it was read from. A redirect input (flush with a target) reloads the counter from a new address and withdraws the instruction on offer. The redirect costs one empty slot on the stream.

The same program store is also visible as 16-bit halfwords on an independent read port, the kind a data bus would use. Every instruction occupies an even/odd halfword pair. The even halfword carries bits 15:0. The odd halfword carries bits 23:16 in its low byte, and its high byte reads as zero. The halfword port has a fixed latency of one cycle and no handshake.

The program store is a computed model. The instruction at index `i` (the program address shifted right by one, taken modulo 2^IDX_W, with IDX_W = 8 by default) is `{8'h80 ^ i[7:0], 16'h1000 + 3*i}`, where the addition is 16 bits wide.

Top module: `insf_top`

Stream rules: a transfer happens in a cycle where `ins_valid && ins_ready && !flush`. While `ins_ready` is low, the counter, `ins_valid`, `ins_pc` and `ins_word` all hold. `flush` takes effect whether or not `ins_ready` is high.

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ins_valid` is 0. The first instruction transferred after reset comes from address 0x000000.
- R2: With `ins_ready` held high and no flush, the stream transfers one instruction per cycle. Each transfer's `ins_pc` is the previous one plus 2.
- R3: `ins_word` always equals the program word at index `ins_pc[IDX_W:1]`, with the content formula given above.
- R4: While `ins_ready` is low and `flush` is low, `ins_valid`, `ins_pc` and `ins_word` keep their values.
- R5: In the cycle after `flush` is high, `ins_valid` is 0. This is the single bubble.
- R6: A flush is taken even when `ins_ready` is low.
- R7: After a flush, the first instruction offered comes from `flush_target` with bit 0 forced to 0.
- R8: The counter wraps modulo 2^23. The instruction after 0x7FFFFE is the one at 0x000000.
- R9: One cycle after `hw_addr` is presented with bit 0 equal to 0, `hw_data` holds bits 15:0 of that instruction.
- R10: One cycle after `hw_addr` is presented with bit 0 equal to 1, `hw_data` holds `{8'h00, bits 23:16}` of that instruction.
- R11: Whenever `ins_valid` is 1, bit 0 of `ins_pc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Redirect fetch to `flush_target` and withdraw the offered instruction |
| flush_target | input | 23 | Redirect address; bit 0 is ignored |
| ins_ready | input | 1 | Downstream accepts the offered instruction; low means stall |
| ins_valid | output | 1 | An instruction is on offer |
| ins_word | output | 24 | Offered instruction word |
| ins_pc | output | 23 | Program address of the offered instruction |
| hw_addr | input | 23 | Halfword read address |
| hw_data | output | 16 | Halfword read data, one cycle after the address |

## Verification
On every cycle, the bound checker watches the even address parity, the hold during a stall, the bubble after a flush, the +2 step between consecutive transfers, the arrival of the cleared-bit target two cycles after a redirect, and the zero upper byte on odd halfword reads. The word contents, the start address after reset, the wrap at the top of the address space, a flush taken during a stall, and the exact halfword values can only be shown by the bench scenarios. In those scenarios, a scoreboard compares every transfer against a queue of expected addresses and words.

// File: rtl/insf_pkg.sv
package insf_pkg;
  localparam int PC_W_D  = 23;
  localparam int INS_W_D = 24;
  localparam int HW_W_D  = 16;
  localparam int IDX_W_D = 8;

  // Computed program content for an (already reduced) instruction index
  function automatic logic [23:0] prog_word(input logic [21:0] idx);
    logic [15:0] lo;
    logic [7:0]  hi;
    lo = 16'h1000 + (idx[15:0] * 16'd3);
    hi = 8'h80 ^ idx[7:0];
    return {hi, lo};
  endfunction
endpackage

// File: rtl/insf_pc_gen.sv
module insf_pc_gen #(
  parameter int PC_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  input  logic            advance,
  output logic [PC_W-1:0] pc
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (redirect) pc <= {target[PC_W-1:1], 1'b0};
    else if (advance)  pc <= pc + STEP;
  end
endmodule

// File: rtl/insf_rom.sv
module insf_rom #(
  parameter int PC_W  = 23,
  parameter int INS_W = 24,
  parameter int HW_W  = 16,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_en,
  input  logic [PC_W-1:0]  f_addr,
  output logic [INS_W-1:0] f_word,
  input  logic [PC_W-1:0]  h_addr,
  output logic [HW_W-1:0]  h_data
);
  import insf_pkg::*;
  localparam int IW = PC_W - 1;
  localparam logic [IW-1:0] IDX_MASK = IW'((64'd1 << IDX_W) - 64'd1);
  localparam int UPPER_W = INS_W - HW_W;

  logic [IW-1:0]    f_idx, h_idx;
  logic [INS_W-1:0] h_word;
  logic [HW_W-1:0]  h_sel;

  assign f_idx  = f_addr[PC_W-1:1] & IDX_MASK;
  assign h_idx  = h_addr[PC_W-1:1] & IDX_MASK;
  assign h_word = INS_W'(prog_word(22'(h_idx)));

  generate
    if (UPPER_W < HW_W) begin : g_pad
      assign h_sel = h_addr[0] ? {{(HW_W-UPPER_W){1'b0}}, h_word[INS_W-1:HW_W]}
                               : h_word[HW_W-1:0];
    end else begin : g_full
      assign h_sel = h_addr[0] ? h_word[HW_W+HW_W-1:HW_W] : h_word[HW_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    f_word <= '0;
    else if (f_en) f_word <= INS_W'(prog_word(22'(f_idx)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_data <= '0;
    else        h_data <= h_sel;
  end
endmodule

// File: rtl/insf_slot.sv
module insf_slot #(
  parameter int PC_W = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect,
  input  logic            advance,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            valid,
  output logic [PC_W-1:0] slot_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      slot_pc <= '0;
    end else if (redirect) begin
      valid   <= 1'b0;
    end else if (advance) begin
      valid   <= 1'b1;
      slot_pc <= fetch_pc;
    end
  end
endmodule

// File: rtl/insf_top.sv
module insf_top #(
  parameter int PC_W  = insf_pkg::PC_W_D,
  parameter int INS_W = insf_pkg::INS_W_D,
  parameter int HW_W  = insf_pkg::HW_W_D,
  parameter int IDX_W = insf_pkg::IDX_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [PC_W-1:0]  flush_target,
  input  logic             ins_ready,
  output logic             ins_valid,
  output logic [INS_W-1:0] ins_word,
  output logic [PC_W-1:0]  ins_pc,
  input  logic [PC_W-1:0]  hw_addr,
  output logic [HW_W-1:0]  hw_data
);
  logic            step;
  logic [PC_W-1:0] fpc;

  assign step = ins_ready & ~flush;

  insf_pc_gen #(.PC_W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .redirect(flush), .target(flush_target),
    .advance(step), .pc(fpc)
  );

  insf_rom #(.PC_W(PC_W), .INS_W(INS_W), .HW_W(HW_W), .IDX_W(IDX_W)) u_rom (
    .clk(clk), .rst_n(rst_n), .f_en(step), .f_addr(fpc), .f_word(ins_word),
    .h_addr(hw_addr), .h_data(hw_data)
  );

  insf_slot #(.PC_W(PC_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .redirect(flush), .advance(step),
    .fetch_pc(fpc), .valid(ins_valid), .slot_pc(ins_pc)
  );
endmodule

// File: rtl/insf_checker.sv
module insf_checker #(
  parameter int PC_W  = 23,
  parameter int INS_W = 24,
  parameter int HW_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [PC_W-1:0]  flush_target,
  input logic             ins_ready,
  input logic             ins_valid,
  input logic [INS_W-1:0] ins_word,
  input logic [PC_W-1:0]  ins_pc,
  input logic [PC_W-1:0]  hw_addr,
  input logic [HW_W-1:0]  hw_data
);
  localparam logic [PC_W-1:0] STEP      = PC_W'(2);
  localparam logic [PC_W-1:0] EVEN_MASK = {{(PC_W-1){1'b1}}, 1'b0};

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r11_pc_even: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> !ins_pc[0]);

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !flush) |=>
      (ins_valid && $stable(ins_word) && $stable(ins_pc)));

  a_r5_flush_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ins_valid);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready && !flush) |=>
      (ins_valid && ins_pc == $past(ins_pc) + STEP));

  a_r7_target_even: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(flush) && !flush && ins_ready) |=>
      (ins_valid && ins_pc == ($past(flush_target, 2) & EVEN_MASK)));

  a_r10_odd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_addr[0]) |-> (hw_data[HW_W-1:8] == '0));
endmodule

bind insf_top insf_checker #(.PC_W(PC_W), .INS_W(INS_W), .HW_W(HW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .flush_target(flush_target),
  .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_word(ins_word),
  .ins_pc(ins_pc), .hw_addr(hw_addr), .hw_data(hw_data)
);

// File: tb/insf_top_tb.sv
module insf_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [22:0] flush_target = '0;
  logic        ins_ready = 1'b0;
  logic        ins_valid;
  logic [23:0] ins_word;
  logic [22:0] ins_pc;
  logic [22:0] hw_addr = '0;
  logic [15:0] hw_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [22:0] exp_q[$];
  logic        m_valid = 1'b0;
  logic [22:0] m_pc = '0;
  logic [22:0] m_fpc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insf_top u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_target(flush_target),
    .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_pc(ins_pc), .hw_addr(hw_addr), .hw_data(hw_data)
  );

  function automatic logic [23:0] exp_word(input logic [22:0] a);
    logic [7:0]  i;
    logic [15:0] lo;
    i  = a[8:1];
    lo = 16'h1000 + ({8'h00, i} * 16'd3);
    return {8'h80 ^ i, lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: advance the expectation model one clock, drive new inputs, predict transfer
  task automatic cyc(input logic rdy, input logic fl, input logic [22:0] tgt);
    @(posedge clk);
    if (flush) begin
      m_valid = 1'b0;
      m_fpc   = {flush_target[22:1], 1'b0};
    end else if (ins_ready) begin
      m_valid = 1'b1;
      m_pc    = m_fpc;
      m_fpc   = m_fpc + 23'd2;
    end
    #1;
    ins_ready    = rdy;
    flush        = fl;
    flush_target = tgt;
    if (m_valid && rdy && !fl) exp_q.push_back(m_pc);
  endtask

  task automatic hw_check(input logic [22:0] a, input string req);
    logic [23:0] w;
    logic [15:0] e;
    w = exp_word(a);
    e = a[0] ? {8'h00, w[23:16]} : w[15:0];
    cyc(1'b0, 1'b0, '0);
    hw_addr = a;
    cyc(1'b0, 1'b0, '0);
    @(negedge clk);
    check(hw_data == e, req, 32'(hw_data), 32'(e));
  endtask

  // Monitor: pops expected items on every real transfer
  always @(negedge clk) begin
    if (rst_n && ins_valid && ins_ready && !flush) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected transfer", 32'(ins_pc), 32'hFFFFFFFF);
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        check(ins_pc == e, "R2 transfer address", 32'(ins_pc), 32'(e));
        check(ins_word == exp_word(e), "R3 instruction word", 32'(ins_word),
              32'(exp_word(e)));
        check(ins_pc[0] == 1'b0, "R11 even address", 32'(ins_pc[0]), 32'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] hold_w;
    logic [22:0] hold_pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(ins_valid == 1'b0, "R1 valid low in reset", 32'(ins_valid), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 / R2: run from reset
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid == 1'b0, "R1 valid low first cycle", 32'(ins_valid), 32'd0);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid && ins_pc == 23'd0, "R1 first address", 32'(ins_pc), 32'd0);
    repeat (10) cyc(1'b1, 1'b0, '0);

    // R4: stall
    cyc(1'b0, 1'b0, '0);
    @(negedge clk);
    hold_w  = ins_word;
    hold_pc = ins_pc;
    repeat (3) cyc(1'b0, 1'b0, '0);
    @(negedge clk);
    check(ins_valid == 1'b1, "R4 valid held", 32'(ins_valid), 32'd1);
    check(ins_pc == hold_pc, "R4 address held", 32'(ins_pc), 32'(hold_pc));
    check(ins_word == hold_w, "R4 word held", 32'(ins_word), 32'(hold_w));
    repeat (4) cyc(1'b1, 1'b0, '0);

    // R5 / R7: flush to odd target
    cyc(1'b1, 1'b1, 23'h000105);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid == 1'b0, "R5 bubble", 32'(ins_valid), 32'd0);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid && ins_pc == 23'h000104, "R7 target bit0 cleared",
          32'(ins_pc), 32'h104);
    repeat (4) cyc(1'b1, 1'b0, '0);

    // R6: flush while stalled
    repeat (2) cyc(1'b0, 1'b0, '0);
    cyc(1'b0, 1'b1, 23'h000200);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid == 1'b0, "R6 flush during stall bubble", 32'(ins_valid), 32'd0);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid && ins_pc == 23'h000200, "R6 flush during stall target",
          32'(ins_pc), 32'h200);
    repeat (3) cyc(1'b1, 1'b0, '0);

    // R8: wrap at top of address space
    cyc(1'b1, 1'b1, 23'h7FFFFE);
    cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_pc == 23'h7FFFFE, "R8 top address", 32'(ins_pc), 32'h7FFFFE);
    cyc(1'b1, 1'b0, '0);
    @(negedge clk);
    check(ins_valid && ins_pc == 23'h000000, "R8 wrap to zero", 32'(ins_pc), 32'd0);
    repeat (3) cyc(1'b1, 1'b0, '0);

    // R9 / R10: halfword reads
    hw_check(23'h000000, "R9 even halfword idx0");
    hw_check(23'h000001, "R10 odd halfword idx0");
    hw_check(23'h00000A, "R9 even halfword idx5");
    hw_check(23'h00000B, "R10 odd halfword idx5");
    hw_check(23'h7FFFFF, "R10 odd halfword top");

    repeat (3) cyc(1'b0, 1'b0, '0);
    check(exp_q.size() == 0, "R2 all expected transfers seen",
          32'(exp_q.size()), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule